// File: doc/BRIEF.md
# Receiver AGC Hold Controller

This block is a sampled-data automatic gain control state machine for a receive front-end amplifier that offers two gain settings, a high-gain one (about 35 dB) and a low-gain one (about 5 dB). A saturation-detect strobe from the analog side engages the low-gain setting. The setting is released only when two conditions hold together. The peak-tracker sample, scaled by 0.8, must sit below the primary slicer threshold. The programmed minimum hold-in time must also have run out. The hold-in time keeps the gain from chattering through long runs of zero bits, and it may be set longer than the decay time of the peak tracker.

A two-bit mode selects normal operation, a defeated mode in which the gain never engages, or a latched mode in which the first saturation event holds low gain until the receiver goes inactive. Whenever the receive-active flag is low, which covers sleep and both transmit modes, the engaged state and the hold timer are cleared. The mode is captured only in that inactive window. The peak sample is an unsigned value from a neighbouring block. The 0.8 scaling is computed as the integer comparison 4*peak < 5*threshold.

Top module: `agc_hold_ctrl`

## Requirements
- R1: After reset, gain_low_o and hold_lock_o are 0.
- R2: With rx_active_i high and the captured mode not defeated (mode code 2'b01), sat_i high at a clock edge sets gain_low_o to 1 after that edge, which is 1 cycle of latency. The same edge loads the hold timer with hold_cycles_i.
- R3: In a mode other than latched (code 2'b10), while engaged with the hold timer at zero, gain_low_o falls after the first edge at which the release request is true and sat_i is low. The release request is thr_i != 0 and 4*peak_i < 5*thr_i.
- R4: After the last load of the hold timer, gain_low_o stays 1 for at least hold_cycles_i+1 cycles while rx_active_i is high. The timer counts down by one per engaged cycle.
- R5: A sat_i strobe while already engaged reloads the hold timer to the full hold_cycles_i value.
- R6: With thr_i == 0, an engaged gain is never released while rx_active_i stays high.
- R7: In defeated mode (2'b01), gain_low_o stays 0 whatever sat_i does.
- R8: In latched mode (2'b10), gain_low_o stays 1 after the first saturation event until rx_active_i goes low.
- R9: rx_active_i low at an edge clears gain_low_o, hold_lock_o and the hold timer after that edge.
- R10: mode_i is captured only at edges where rx_active_i is low. A change while active has no effect until the next activation. Codes 2'b00 and 2'b11 both mean normal.
- R11: hold_lock_o is 1 exactly when engaged and release is blocked, meaning the hold timer is non-zero or the mode is latched.
- R12: The release comparison is strict. With 4*peak_i == 5*thr_i there is no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_active_i | input | 1 | Receiver active. Low in sleep and transmit |
| mode_i | input | 2 | 00/11 normal, 01 defeated, 10 latched |
| sat_i | input | 1 | Saturation-detect strobe |
| peak_i | input | PW | Unsigned peak-tracker sample |
| thr_i | input | PW | Primary slicer threshold |
| hold_cycles_i | input | HW | Minimum hold-in time in cycles |
| gain_low_o | output | 1 | 1 selects the low-gain setting |
| hold_lock_o | output | 1 | Engaged and release currently blocked |

## Verification
Directed sequences drive a single strobe followed by an immediate release request, which separates the hold-in count from the comparator. Mid-hold strobes show whether the timer reloads or only extends. Peak values one step either side of 1.25*threshold, and a zero threshold, pin down the strict scaled comparison and the zero-threshold lockout. Mode changes while active and inactive tell apart capture-when-idle from live decoding, and a long constrained-random run with mixed strobes, peaks, thresholds and activity toggles is compared cycle by cycle against a bench reference model.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    AGC_NORMAL   = 2'b00,
    AGC_DEFEAT   = 2'b01,
    AGC_LATCH    = 2'b10,
    AGC_NORMAL_B = 2'b11
  } agc_mode_e;
endpackage

// File: rtl/agc_mode_reg.sv
module agc_mode_reg
  import agc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      capture_i,
  input  logic [1:0] mode_i,
  output agc_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_o <= AGC_NORMAL;
    else if (capture_i) mode_o <= agc_mode_e'(mode_i);
  end
endmodule

// File: rtl/agc_release_cmp.sv
module agc_release_cmp #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] peak_i,
  input  logic [PW-1:0] thr_i,
  output logic          rel_o
);
  localparam int CW = PW + 3;
  logic [CW-1:0] peak_x4, thr_x5;

  always_comb begin
    peak_x4 = {1'b0, peak_i, 2'b00};
    thr_x5  = {3'b000, thr_i} + {1'b0, thr_i, 2'b00};
    rel_o   = (thr_i != '0) && (peak_x4 < thr_x5);
  end
endmodule

// File: rtl/agc_hold_timer.sv
module agc_hold_timer #(
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [HW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && !zero_o)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/agc_hold_ctrl.sv
module agc_hold_ctrl
  import agc_pkg::*;
#(
  parameter int PW = 8,
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_active_i,
  input  logic [1:0]    mode_i,
  input  logic          sat_i,
  input  logic [PW-1:0] peak_i,
  input  logic [PW-1:0] thr_i,
  input  logic [HW-1:0] hold_cycles_i,
  output logic          gain_low_o,
  output logic          hold_lock_o
);
  agc_mode_e mode_q;
  logic      rel_req, tmr_zero, sat_ok, is_latch, eng_q;

  agc_mode_reg u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (!rx_active_i),
    .mode_i    (mode_i),
    .mode_o    (mode_q)
  );

  agc_release_cmp #(.PW(PW)) u_cmp (
    .peak_i (peak_i),
    .thr_i  (thr_i),
    .rel_o  (rel_req)
  );

  assign sat_ok   = sat_i && (mode_q != AGC_DEFEAT);
  assign is_latch = (mode_q == AGC_LATCH);

  agc_hold_timer #(.HW(HW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!rx_active_i),
    .load_i     (sat_ok),
    .load_val_i (hold_cycles_i),
    .dec_i      (eng_q),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   eng_q <= 1'b0;
    else if (!rx_active_i)                         eng_q <= 1'b0;
    else if (sat_ok)                               eng_q <= 1'b1;
    else if (tmr_zero && rel_req && !is_latch)     eng_q <= 1'b0;
  end

  assign gain_low_o  = eng_q;
  assign hold_lock_o = eng_q && (!tmr_zero || is_latch);
endmodule

// File: rtl/agc_hold_ctrl_chk.sv
module agc_hold_ctrl_chk #(
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_active_i,
  input logic          sat_i,
  input logic [PW-1:0] thr_i,
  input logic [1:0]    mode_q,
  input logic          gain_low_o,
  input logic          hold_lock_o
);
  AST_ENGAGE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i && sat_i && mode_q != 2'b01 |=> gain_low_o); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i && hold_lock_o |=> gain_low_o); // R4
  AST_ZERO_THR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i && gain_low_o && thr_i == '0 |=> gain_low_o); // R6
  AST_DEFEAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i && mode_q == 2'b01 |=> !gain_low_o); // R7
  AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i && mode_q == 2'b10 && gain_low_o |=> gain_low_o); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_active_i |=> !gain_low_o && !hold_lock_o); // R9
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_active_i) |-> $stable(mode_q)); // R10
  AST_LOCK_IMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_lock_o |-> gain_low_o); // R11
endmodule

bind agc_hold_ctrl agc_hold_ctrl_chk #(.PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_active_i (rx_active_i),
  .sat_i       (sat_i),
  .thr_i       (thr_i),
  .mode_q      (mode_q),
  .gain_low_o  (gain_low_o),
  .hold_lock_o (hold_lock_o)
);

// File: tb/sim_agc_hold_ctrl.sv
`timescale 1ns/1ps
module sim_agc_hold_ctrl;
  localparam int PW = 8;
  localparam int HW = 8;

  logic clk = 0, rst_n = 0;
  logic act = 0, sat = 0;
  logic [1:0] mode = 0;
  logic [PW-1:0] peak = 0, thr = 0;
  logic [HW-1:0] hold = 0;
  logic gain_low, lock;

  int n_run = 0, n_fail = 0;
  int m_tmr = 0;
  bit m_eng = 0;
  logic [1:0] m_mode = 0;

  always #4 clk = ~clk;

  agc_hold_ctrl #(.PW(PW), .HW(HW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_active_i(act), .mode_i(mode),
    .sat_i(sat), .peak_i(peak), .thr_i(thr), .hold_cycles_i(hold),
    .gain_low_o(gain_low), .hold_lock_o(lock));

  function automatic bit rel_fn(int p, int t);
    return (t != 0) && (4 * p < 5 * t);
  endfunction

  task automatic chk(string tag, bit act_v, bit exp_v);
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit a, bit s, int p, int t, int m);
    act = a; sat = s; peak = p[PW-1:0]; thr = t[PW-1:0]; mode = m[1:0];
    @(posedge clk);
    if (!a) begin m_eng = 0; m_tmr = 0; m_mode = m[1:0]; end
    else if (s && m_mode != 2'b01) begin m_eng = 1; m_tmr = hold; end
    else if (m_eng) begin
      if (m_tmr != 0) m_tmr--;
      else if (m_mode != 2'b10 && rel_fn(p, t)) m_eng = 0;
    end
    @(negedge clk);
    chk({tag, " gain"}, gain_low, m_eng);
    chk({tag, " R11 lock"}, lock, m_eng && (m_tmr != 0 || m_mode == 2'b10));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    hold = 4;
    #20;
    chk("R1 reset gain", gain_low, 0);
    chk("R1 reset lock", lock, 0);
    @(negedge clk); rst_n = 1;
    step("R10 idle capture", 0, 0, 0, 10, 0);
    // R2 / R4 / R3 normal
    step("R2 engage", 1, 1, 200, 10, 0);
    chk("R2 direct", gain_low, 1);
    for (int i = 0; i < 4; i++) step("R4 hold", 1, 0, 0, 10, 0);
    chk("R4 still engaged", gain_low, 1);
    step("R3 release", 1, 0, 0, 10, 0);
    chk("R3 direct", gain_low, 0);
    // R5 reload
    step("R5 engage", 1, 1, 200, 10, 0);
    step("R5 hold", 1, 0, 0, 10, 0);
    step("R5 hold", 1, 0, 0, 10, 0);
    step("R5 resat", 1, 1, 0, 10, 0);
    for (int i = 0; i < 4; i++) step("R5 reloaded", 1, 0, 0, 10, 0);
    chk("R5 direct", gain_low, 1);
    // R12 boundary: thr 8, peak 10 -> 40 vs 40 no release
    step("R12 equal", 1, 0, 10, 8, 0);
    step("R12 equal", 1, 0, 10, 8, 0);
    chk("R12 direct", gain_low, 1);
    step("R12 below", 1, 0, 9, 8, 0);
    chk("R12 below direct", gain_low, 0);
    // R6 zero threshold
    step("R6 engage", 1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R6 zero thr", 1, 0, 0, 0, 0);
    chk("R6 direct", gain_low, 1);
    // R9 inactive clear
    step("R9 idle", 0, 0, 0, 0, 1);
    chk("R9 direct", gain_low, 0);
    // R7 defeat
    step("R7 engage try", 1, 1, 200, 10, 1);
    chk("R7 direct", gain_low, 0);
    // R10 change while active has no effect
    step("R10 live change", 1, 1, 200, 10, 2);
    step("R10 live change", 1, 1, 200, 10, 2);
    chk("R10 direct", gain_low, 0);
    step("R10 idle", 0, 0, 0, 10, 2);
    // R8 latched
    step("R8 engage", 1, 1, 200, 10, 2);
    for (int i = 0; i < 10; i++) step("R8 latched", 1, 0, 0, 10, 2);
    chk("R8 direct", gain_low, 1);
    step("R8 R9 exit", 0, 0, 0, 10, 3);
    chk("R8 cleared", gain_low, 0);
    // constrained random, R3 R4 R5 mix
    for (int i = 0; i < 3000; i++) begin
      hold = HW'($urandom_range(0, 6));
      step("R3 R4 R5 random", ($urandom_range(0, 19) != 0), ($urandom_range(0, 9) == 0),
           $urandom_range(0, 40), $urandom_range(0, 30), $urandom_range(0, 3));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule